// File: doc/BRIEF.md
# Parallel Port Register Access Sequencer

This block sits on the host side of a legacy parallel port and carries out one register access at a time to an IDE bridge attached to that port. A request names a bank (task file or control), a register index, the direction, a value for writes and a transfer mode from 0 to 5. The engine then plays out the port activity for that mode, one step per clock. Each step does exactly one of these things: drive the data lines, drive the control lines, pulse an EPP address or data strobe, or capture a status or data input.

Modes 0 to 2 form a command byte from the register address with a mode-specific XOR constant. The bridge then returns the byte in one of three ways: as two nibbles on status port 1, as a 5-bit and 3-bit split across two status ports, or directly on the data bus. Modes 3 to 5 use EPP address and data cycles. The engine reports completion with a one-cycle `done` and holds the joined read byte on `rd_data`.

Top module: `ppr_seq`

## Requirements
- R1: The step address is the 7-bit index with bit 7 set to `req_bank` (1 = control bank adds 0x80, 0 = task-file bank adds nothing).
- R2: A mode 0 read issues, one step per cycle: data=addr^0x39, ctrl=0x01, ctrl=0x03, data=addr^0x39, capture status 1 (first), ctrl=0x01, capture status 1 (second), ctrl=0x04.
- R3: The mode 0 read result is {second[7:4], first[7:4]}.
- R4: A mode 1 read issues: data=c, ctrl=0x01, data=c&0x37, ctrl=0x03, ctrl=0x05, data=c|0xF0, capture status 1, capture status 2, ctrl=0x04, where c=addr^0x31.
- R5: The mode 1 read result is {status2[3:1], status1[7:3]}.
- R6: A mode 2 read issues data=addr^0x29, ctrl=0x01, 0x21, 0x23, captures the data bus input, and ends with ctrl=0x04. The result is the captured byte.
- R7: A read in modes 3, 4 or 5 issues an EPP address cycle carrying addr, ctrl=0x24, and an EPP read cycle that captures the data bus input, then ctrl=0x04. The result is the captured byte. EPP strobes occur only in these modes.
- R8: A write in modes 0 to 2 issues data=addr^0x19, ctrl=0x01, data=value, ctrl=0x03, ctrl=0x04.
- R9: A write in modes 3 to 5 issues an EPP address cycle with addr^0x40, an EPP data write cycle with the value, then ctrl=0x04. At most one EPP strobe is high in any cycle.
- R10: `busy` is high from the cycle after acceptance through the cycle of the last step, which is one cycle per step. `done` is high for the single following cycle, with `busy` low and ctrl at 0x04.
- R11: A request presented while `busy` is high is ignored and has no effect on the ports.
- R12: Mode 6 or 7 is accepted and raises `done` in the next cycle with `rd_data`=0xFF, with no port activity.
- R13: After reset, data=0x00, ctrl=0x04, all strobes low, `busy`=0, `done`=0 and `rd_data`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | 1 = control bank, 0 = task-file bank |
| req_index | input | 7 | Register index |
| req_wdata | input | 8 | Write value |
| req_mode | input | 3 | Transfer mode, 0 to 5 valid |
| pp_data_i | input | 8 | Data bus read-back and EPP read data |
| pp_stat1_i | input | 8 | Status port 1 |
| pp_stat2_i | input | 8 | Status port 2 |
| pp_data_o | output | 8 | Data lines driven to the port |
| pp_ctrl_o | output | 8 | Control lines driven to the port |
| epp_addr_stb | output | 1 | EPP address write cycle, data lines carry the address |
| epp_wr_stb | output | 1 | EPP data write cycle, data lines carry the value |
| epp_rd_stb | output | 1 | EPP data read cycle, data bus captured |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Joined read byte, or 0xFF for a bad mode |

## Verification
The assertions check on every cycle that `done` never coincides with `busy`, and that a completed sequence leaves the control lines at 0x04. They also check that the latched request stays fixed while busy, that EPP strobes are mutually exclusive and appear only in modes 3 to 5, and that a bad mode yields 0xFF. Only the bench's scenarios can show the exact step order, the XOR command values and the bit placement of the nibble and 5/3 joins. For this, a behavioural model is compared against every output on every clock, while the status and data inputs change each cycle.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  typedef enum logic [3:0] {
    OP_DATA,      // drive data lines
    OP_CTRL,      // drive control lines
    OP_S1_A,      // capture status 1 into first byte
    OP_S1_B,      // capture status 1 into second byte
    OP_S2_B,      // capture status 2 into second byte
    OP_BUS_A,     // capture data bus into first byte
    OP_EPP_ADDR,  // EPP address cycle
    OP_EPP_WR,    // EPP data write cycle
    OP_EPP_RD     // EPP data read cycle, capture into first byte
  } op_e;

  typedef enum logic [2:0] {
    SQ_RD_NIB,
    SQ_RD_53,
    SQ_RD_BYTE,
    SQ_RD_EPP,
    SQ_WR_BYTE,
    SQ_WR_EPP
  } seq_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] val;
    logic       last;
  } step_t;

  localparam logic [7:0] K_RD_NIB  = 8'h39;
  localparam logic [7:0] K_RD_53   = 8'h31;
  localparam logic [7:0] K_RD_BYTE = 8'h29;
  localparam logic [7:0] K_WR_BYTE = 8'h19;
  localparam logic [7:0] K_WR_EPP  = 8'h40;
  localparam logic [7:0] CTRL_IDLE = 8'h04;
  localparam logic [7:0] ERR_BYTE  = 8'hFF;

endpackage

// File: rtl/ppr_step_rom.sv
module ppr_step_rom
  import ppr_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  seq_e              seq,
  input  logic [STEP_W-1:0] idx,
  input  logic [7:0]        cmd,
  input  logic [7:0]        wval,
  output step_t             step
);

  function automatic step_t mk(op_e o, logic [7:0] v, logic l);
    step_t s;
    s.op   = o;
    s.val  = v;
    s.last = l;
    return s;
  endfunction

  always_comb begin
    step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
    unique case (seq)
      SQ_RD_NIB: begin
        case (idx)
          0: step = mk(OP_DATA, cmd,   1'b0);
          1: step = mk(OP_CTRL, 8'h01, 1'b0);
          2: step = mk(OP_CTRL, 8'h03, 1'b0);
          3: step = mk(OP_DATA, cmd,   1'b0);
          4: step = mk(OP_S1_A, 8'h00, 1'b0);
          5: step = mk(OP_CTRL, 8'h01, 1'b0);
          6: step = mk(OP_S1_B, 8'h00, 1'b0);
          default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
        endcase
      end
      SQ_RD_53: begin
        case (idx)
          0: step = mk(OP_DATA, cmd,          1'b0);
          1: step = mk(OP_CTRL, 8'h01,        1'b0);
          2: step = mk(OP_DATA, cmd & 8'h37,  1'b0);
          3: step = mk(OP_CTRL, 8'h03,        1'b0);
          4: step = mk(OP_CTRL, 8'h05,        1'b0);
          5: step = mk(OP_DATA, cmd | 8'hF0,  1'b0);
          6: step = mk(OP_S1_A, 8'h00,        1'b0);
          7: step = mk(OP_S2_B, 8'h00,        1'b0);
          default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
        endcase
      end
      SQ_RD_BYTE: begin
        case (idx)
          0: step = mk(OP_DATA,  cmd,   1'b0);
          1: step = mk(OP_CTRL,  8'h01, 1'b0);
          2: step = mk(OP_CTRL,  8'h21, 1'b0);
          3: step = mk(OP_CTRL,  8'h23, 1'b0);
          4: step = mk(OP_BUS_A, 8'h00, 1'b0);
          default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
        endcase
      end
      SQ_RD_EPP: begin
        case (idx)
          0: step = mk(OP_EPP_ADDR, cmd,   1'b0);
          1: step = mk(OP_CTRL,     8'h24, 1'b0);
          2: step = mk(OP_EPP_RD,   8'h00, 1'b0);
          default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
        endcase
      end
      SQ_WR_BYTE: begin
        case (idx)
          0: step = mk(OP_DATA, cmd,   1'b0);
          1: step = mk(OP_CTRL, 8'h01, 1'b0);
          2: step = mk(OP_DATA, wval,  1'b0);
          3: step = mk(OP_CTRL, 8'h03, 1'b0);
          default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
        endcase
      end
      SQ_WR_EPP: begin
        case (idx)
          0: step = mk(OP_EPP_ADDR, cmd,  1'b0);
          1: step = mk(OP_EPP_WR,   wval, 1'b0);
          default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
        endcase
      end
      default: step = mk(OP_CTRL, CTRL_IDLE, 1'b1);
    endcase
  end

endmodule

// File: rtl/ppr_join.sv
module ppr_join
  import ppr_pkg::*;
#(
  parameter int LO_W = 5  // width taken from the first byte in the split read
) (
  input  seq_e       seq,
  input  logic [7:0] first,
  input  logic [7:0] second,
  output logic [7:0] joined
);

  localparam int HI_W = 8 - LO_W;

  always_comb begin
    unique case (seq)
      SQ_RD_NIB: joined = {second[7:4], first[7:4]};
      SQ_RD_53:  joined = {second[HI_W:1], first[7:8-LO_W]};
      default:   joined = first;
    endcase
  end

endmodule

// File: rtl/ppr_seq.sv
module ppr_seq
  import ppr_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int MODE_W = 3,
  parameter int STEP_W = 4,
  parameter int MODE_MAX = 5,
  parameter int EPP_FIRST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_bank,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [7:0]        req_wdata,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [7:0]        pp_data_i,
  input  logic [7:0]        pp_stat1_i,
  input  logic [7:0]        pp_stat2_i,
  output logic [7:0]        pp_data_o,
  output logic [7:0]        pp_ctrl_o,
  output logic              epp_addr_stb,
  output logic              epp_wr_stb,
  output logic              epp_rd_stb,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data
);

  localparam logic [MODE_W-1:0] M_MAX = MODE_W'(MODE_MAX);
  localparam logic [MODE_W-1:0] M_EPP = MODE_W'(EPP_FIRST);

  // request decode
  logic [7:0] addr_n, cmd_n;
  seq_e       seq_n;
  logic       mode_ok;

  assign addr_n  = {req_bank, req_index};
  assign mode_ok = (req_mode <= M_MAX);

  always_comb begin
    if (req_write) begin
      seq_n = (req_mode < M_EPP) ? SQ_WR_BYTE : SQ_WR_EPP;
    end else begin
      unique case (req_mode)
        MODE_W'(0): seq_n = SQ_RD_NIB;
        MODE_W'(1): seq_n = SQ_RD_53;
        MODE_W'(2): seq_n = SQ_RD_BYTE;
        default:    seq_n = SQ_RD_EPP;
      endcase
    end
    unique case (seq_n)
      SQ_RD_NIB:  cmd_n = addr_n ^ K_RD_NIB;
      SQ_RD_53:   cmd_n = addr_n ^ K_RD_53;
      SQ_RD_BYTE: cmd_n = addr_n ^ K_RD_BYTE;
      SQ_WR_BYTE: cmd_n = addr_n ^ K_WR_BYTE;
      SQ_WR_EPP:  cmd_n = addr_n ^ K_WR_EPP;
      default:    cmd_n = addr_n;
    endcase
  end

  // latched request
  seq_e              seq_q;
  logic [7:0]        cmd_q, wval_q, first_q, second_q;
  logic [STEP_W-1:0] step_q;
  logic [MODE_W-1:0] mode_q;

  step_t      cur;
  logic [7:0] joined;
  logic       is_read;

  assign is_read = (seq_q != SQ_WR_BYTE) && (seq_q != SQ_WR_EPP);

  ppr_step_rom #(.STEP_W(STEP_W)) u_rom (
    .seq  (seq_q),
    .idx  (step_q),
    .cmd  (cmd_q),
    .wval (wval_q),
    .step (cur)
  );

  ppr_join #(.LO_W(5)) u_join (
    .seq    (seq_q),
    .first  (first_q),
    .second (second_q),
    .joined (joined)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_data_o    <= 8'h00;
      pp_ctrl_o    <= CTRL_IDLE;
      epp_addr_stb <= 1'b0;
      epp_wr_stb   <= 1'b0;
      epp_rd_stb   <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      rd_data      <= 8'h00;
      seq_q        <= SQ_RD_NIB;
      cmd_q        <= 8'h00;
      wval_q       <= 8'h00;
      first_q      <= 8'h00;
      second_q     <= 8'h00;
      step_q       <= '0;
      mode_q       <= '0;
    end else begin
      done         <= 1'b0;
      epp_addr_stb <= 1'b0;
      epp_wr_stb   <= 1'b0;
      epp_rd_stb   <= 1'b0;
      if (busy) begin
        unique case (cur.op)
          OP_DATA:     pp_data_o <= cur.val;
          OP_CTRL:     pp_ctrl_o <= cur.val;
          OP_S1_A:     first_q   <= pp_stat1_i;
          OP_S1_B:     second_q  <= pp_stat1_i;
          OP_S2_B:     second_q  <= pp_stat2_i;
          OP_BUS_A:    first_q   <= pp_data_i;
          OP_EPP_ADDR: begin pp_data_o <= cur.val; epp_addr_stb <= 1'b1; end
          OP_EPP_WR:   begin pp_data_o <= cur.val; epp_wr_stb   <= 1'b1; end
          OP_EPP_RD:   begin first_q   <= pp_data_i; epp_rd_stb <= 1'b1; end
          default:     ;
        endcase
        if (cur.last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (is_read) rd_data <= joined;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (req_valid) begin
        mode_q <= req_mode;
        if (!mode_ok) begin
          done    <= 1'b1;
          rd_data <= ERR_BYTE;
        end else begin
          busy   <= 1'b1;
          step_q <= '0;
          seq_q  <= seq_n;
          cmd_q  <= cmd_n;
          wval_q <= req_wdata;
        end
      end
    end
  end

  // R10: completion pulse never overlaps a running sequence
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: a finished sequence leaves the control lines idle
  a_r10_ctrl_idle: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (pp_ctrl_o == CTRL_IDLE));

  // R11: the latched request does not move while busy
  a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(mode_q) && $stable(cmd_q) && $stable(wval_q)));

  // R12: bad mode completes at once with the error byte
  a_r12_bad_mode: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !busy && (req_mode > M_MAX)))
      |-> (done && rd_data == ERR_BYTE));

  // R9: EPP strobes are mutually exclusive
  a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({epp_addr_stb, epp_wr_stb, epp_rd_stb}));

  // R7: EPP strobes only in EPP modes
  a_r7_epp_only: assert property (@(posedge clk) disable iff (rst)
    (epp_addr_stb || epp_wr_stb || epp_rd_stb) |-> (mode_q >= M_EPP && mode_q <= M_MAX));

endmodule

// File: tb/sim_ppr_seq.sv
module sim_ppr_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [6:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic [2:0] req_mode = '0;
  logic [7:0] pp_data_i = '0, pp_stat1_i = '0, pp_stat2_i = '0;
  logic [7:0] pp_data_o, pp_ctrl_o, rd_data;
  logic       epp_addr_stb, epp_wr_stb, epp_rd_stb, busy, done;

  always #5 clk = ~clk;

  ppr_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_index(req_index), .req_wdata(req_wdata),
    .req_mode(req_mode), .pp_data_i(pp_data_i), .pp_stat1_i(pp_stat1_i),
    .pp_stat2_i(pp_stat2_i), .pp_data_o(pp_data_o), .pp_ctrl_o(pp_ctrl_o),
    .epp_addr_stb(epp_addr_stb), .epp_wr_stb(epp_wr_stb), .epp_rd_stb(epp_rd_stb),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  int tests = 0;
  int fails = 0;
  bit rnd_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // op codes: 0 data, 1 ctrl, 2 stat1->a, 3 stat1->b, 4 stat2->b,
  //           5 bus->a, 6 epp addr, 7 epp write, 8 epp read->a
  int         q_op[$];
  int         q_val[$];
  logic [7:0] ma, mb;
  logic [7:0] m_data, m_ctrl, m_rd;
  bit         m_ea, m_ew, m_er, m_busy, m_done, m_isrd;
  int         m_kind;
  string      m_tag = "R13";

  task automatic push(int o, int v);
    q_op.push_back(o);
    q_val.push_back(v);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q_op.delete(); q_val.delete();
      m_data = 8'h00; m_ctrl = 8'h04; m_rd = 8'h00;
      m_ea = 0; m_ew = 0; m_er = 0; m_busy = 0; m_done = 0;
      ma = 0; mb = 0; m_kind = 0; m_isrd = 0;
    end else begin
      m_done = 0; m_ea = 0; m_ew = 0; m_er = 0;
      if (q_op.size() > 0) begin
        int o, v;
        o = q_op.pop_front();
        v = q_val.pop_front();
        case (o)
          0: m_data = v[7:0];
          1: m_ctrl = v[7:0];
          2: ma = pp_stat1_i;
          3: mb = pp_stat1_i;
          4: mb = pp_stat2_i;
          5: ma = pp_data_i;
          6: begin m_data = v[7:0]; m_ea = 1; end
          7: begin m_data = v[7:0]; m_ew = 1; end
          default: begin ma = pp_data_i; m_er = 1; end
        endcase
        if (q_op.size() == 0) begin
          m_busy = 0;
          m_done = 1;
          if (m_isrd) begin
            if (m_kind == 0)      m_rd = {mb[7:4], ma[7:4]};
            else if (m_kind == 1) m_rd = {mb[3:1], ma[7:3]};
            else                  m_rd = ma;
          end
        end
      end else if (req_valid) begin
        int a;
        a = req_index + (req_bank ? 128 : 0);
        if (req_mode > 5) begin
          m_done = 1; m_rd = 8'hFF; m_tag = "R12";
        end else begin
          m_busy = 1;
          m_isrd = !req_write;
          if (req_write && req_mode < 3) begin
            m_kind = 4; m_tag = "R8";
            push(0, a ^ 'h19); push(1, 1); push(0, req_wdata); push(1, 3); push(1, 4);
          end else if (req_write) begin
            m_kind = 5; m_tag = "R9";
            push(6, a ^ 'h40); push(7, req_wdata); push(1, 4);
          end else if (req_mode == 0) begin
            m_kind = 0; m_tag = "R2";
            push(0, a ^ 'h39); push(1, 1); push(1, 3); push(0, a ^ 'h39);
            push(2, 0); push(1, 1); push(3, 0); push(1, 4);
          end else if (req_mode == 1) begin
            m_kind = 1; m_tag = "R4";
            push(0, a ^ 'h31); push(1, 1); push(0, (a ^ 'h31) & 'h37);
            push(1, 3); push(1, 5); push(0, (a ^ 'h31) | 'hF0);
            push(2, 0); push(4, 0); push(1, 4);
          end else if (req_mode == 2) begin
            m_kind = 2; m_tag = "R6";
            push(0, a ^ 'h29); push(1, 1); push(1, 'h21); push(1, 'h23);
            push(5, 0); push(1, 4);
          end else begin
            m_kind = 3; m_tag = "R7";
            push(6, a); push(1, 'h24); push(8, 0); push(1, 4);
          end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(pp_data_o == m_data, {m_tag, " data"}, pp_data_o, m_data);
      chk(pp_ctrl_o == m_ctrl, {m_tag, " ctrl"}, pp_ctrl_o, m_ctrl);
      chk({epp_addr_stb, epp_wr_stb, epp_rd_stb} == {m_ea, m_ew, m_er},
          {m_tag, " strobes"}, {epp_addr_stb, epp_wr_stb, epp_rd_stb}, {m_ea, m_ew, m_er});
      chk(busy == m_busy, "R10 busy", busy, m_busy);
      chk(done == m_done, "R10 done", done, m_done);
      chk(rd_data == m_rd, {m_tag, " rd_data"}, rd_data, m_rd);
    end
  end

  // randomised inputs in the free-running phase
  always @(negedge clk) begin
    if (rnd_on) begin
      pp_data_i  <= 8'($urandom);
      pp_stat1_i <= 8'($urandom);
      pp_stat2_i <= 8'($urandom);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic start(bit wr, bit bank, int idx, int wv, int mode);
    req_valid = 1; req_write = wr; req_bank = bank;
    req_index = 7'(idx); req_wdata = 8'(wv); req_mode = 3'(mode);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output int nbusy);
    nbusy = 0;
    for (int g = 0; g < 100 && !done; g++) begin
      if (busy) nbusy++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(pp_data_o == 8'h00 && pp_ctrl_o == 8'h04 && !busy && !done && rd_data == 8'h00 &&
        !epp_addr_stb && !epp_wr_stb && !epp_rd_stb, "R13 reset", pp_ctrl_o, 8'h04);
    rst = 0;
    pp_stat1_i = 8'h5C; pp_stat2_i = 8'h0A; pp_data_i = 8'h3E;
    @(negedge clk);

    // R2/R3: mode 0 read, index 7
    start(0, 0, 7, 0, 0);
    @(negedge clk);
    chk(pp_data_o == 8'h3E, "R2 first command", pp_data_o, 8'h3E);
    wait_done(n);
    chk(n == 7, "R10 busy cycles mode0", n, 7);   // one already elapsed before wait
    chk(rd_data == 8'h55, "R3 nibble join", rd_data, 8'h55);
    chk(pp_ctrl_o == 8'h04, "R10 ctrl idle", pp_ctrl_o, 8'h04);
    @(negedge clk);

    // R4/R5: mode 1 read, 5/3 join
    pp_stat1_i = 8'hB8;
    start(0, 0, 3, 0, 1);
    wait_done(n);
    chk(n == 9, "R10 busy cycles mode1", n, 9);
    chk(rd_data == 8'hB7, "R5 5/3 join", rd_data, 8'hB7);
    @(negedge clk);

    // R6: mode 2 read
    start(0, 0, 2, 0, 2);
    @(negedge clk);
    chk(pp_data_o == 8'h2B, "R6 command", pp_data_o, 8'h2B);
    wait_done(n);
    chk(rd_data == 8'h3E, "R6 bus byte", rd_data, 8'h3E);
    @(negedge clk);

    // R1/R7: EPP read from control bank
    pp_data_i = 8'hC3;
    start(0, 1, 5, 0, 3);
    @(negedge clk);
    chk(epp_addr_stb && pp_data_o == 8'h85, "R1 control bank address", pp_data_o, 8'h85);
    wait_done(n);
    chk(rd_data == 8'hC3, "R7 EPP read byte", rd_data, 8'hC3);
    @(negedge clk);

    // R8: byte-mode write
    start(1, 0, 6, 'hA5, 2);
    @(negedge clk);
    chk(pp_data_o == 8'h1F, "R8 write command", pp_data_o, 8'h1F);
    wait_done(n);
    chk(n == 4, "R10 busy cycles write", n, 4);
    chk(rd_data == 8'hC3, "R8 rd_data kept", rd_data, 8'hC3);
    @(negedge clk);

    // R9: EPP write
    start(1, 1, 6, 'h5A, 5);
    @(negedge clk);
    chk(epp_addr_stb && pp_data_o == 8'hC6, "R9 EPP address", pp_data_o, 8'hC6);
    @(negedge clk);
    chk(epp_wr_stb && pp_data_o == 8'h5A, "R9 EPP data", pp_data_o, 8'h5A);
    wait_done(n);
    @(negedge clk);

    // R12: unsupported mode
    start(0, 0, 1, 0, 6);
    chk(done && !busy && rd_data == 8'hFF && pp_ctrl_o == 8'h04, "R12 bad mode", rd_data, 8'hFF);
    @(negedge clk);

    // R11: requests while busy are ignored
    pp_stat1_i = 8'h5C;
    start(0, 0, 7, 0, 0);
    req_valid = 1; req_write = 1; req_mode = 3'd3; req_wdata = 8'h99;
    repeat (3) @(negedge clk);
    chk(!epp_addr_stb && !epp_wr_stb, "R11 no EPP activity", epp_addr_stb, 0);
    req_valid = 0;
    wait_done(n);
    chk(rd_data == 8'h55, "R11 first request result", rd_data, 8'h55);
    @(negedge clk);
    chk(!busy, "R11 no second sequence", busy, 0);

    // random phase: every output compared each cycle against the model
    rnd_on = 1;
    for (int k = 0; k < 80; k++) begin
      start(1'($urandom), 1'($urandom), int'($urandom % 128), int'($urandom % 256),
            int'($urandom % 8));
      wait_done(n);
      @(negedge clk);
    end
    rnd_on = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule